// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the read side of a 512-byte serial memory that answers on a two-wire bus. A system clock oversamples the clock and data lines. From those samples the block finds Start, repeated Start and Stop conditions. It compares the first byte after each Start against its select code and then serves reads from an internal byte array. The data line is open-drain: the block only decides when to pull it low.

The read address comes from an internal counter, and every byte sent moves the counter on by one. The counter keeps its value between transactions. There are two ways to read:

- A bare read select returns the byte at the counter (current read).
- A write select followed by one address byte loads the counter, and a repeated Start with a matching read select then returns the data at that address (random read).

While the master acknowledges, bytes keep coming. A not-acknowledge makes the block let go of the bus until the next Start. A side port fills the array before use. The write-control pin has no effect on any read.

Top module: `i2cr_eeprom_rd`

## Requirements
- R1: The array holds 512 bytes. A side-port write of `pl_data_i` to `pl_addr_i` is returned by any later bus read of that address.
- R2: The level of `wc_i` changes neither the acknowledges nor the data of any read.
- R3: After each data byte is loaded for output, the address counter advances by one. It wraps from 511 to 0, so a sequential read continues across the end of the array.
- R4: Select byte bits 7:4 = 1010, bits 3:2 = `chip_sel_i`, bit 1 = address bit 8, bit 0 = direction (0 write, 1 read). A write select followed by one address byte is acknowledged twice and loads the counter with {select bit 1, address byte}.
- R5: After such an address load, a repeated Start with a read select whose bits 7:1 equal those of the write select is acknowledged and the loaded address is served. If bits 7:1 differ, the select receives no acknowledge and no data is driven.
- R6: A read select that follows a Start is acknowledged and returns the byte at the counter. The counter keeps its value across Stop conditions, including a value loaded by an address write that was never followed by data.
- R7: A master acknowledge after a data byte causes the next byte to be sent. After a master not-acknowledge, the block drives nothing until the next Start.
- R8: A select byte whose bits 7:2 do not match gets no acknowledge, and the block stays silent until the next Start.
- R9: The block pulls SDA low only for its acknowledge bits and for data zeros. Data is sent most significant bit first, and the drive changes only while SCL is low.
- R10: After reset the block drives nothing and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wc_i | input | 1 | Write-control pin, has no effect on reads |
| chip_sel_i | input | 2 | Strap value matched against select bits 3:2 |
| pl_we_i | input | 1 | Side-port write strobe |
| pl_addr_i | input | 9 | Side-port byte address |
| pl_data_i | input | 8 | Side-port write data |

## Verification
The bench goes after the sequential read that crosses address 511. A counter that saturates, or that fails to wrap, returns byte 511 twice or returns a wrong byte after it.

It also sends a repeated Start whose read select differs from the write select only in the address-8 bit. A design that checks just the device bits would acknowledge that select and send data.

After a refused select, and again after a master not-acknowledge, it keeps clocking the bus. A design that keeps driving would corrupt those bits with zeros.

A later current read must return the byte just past the last one sent, or the byte at an address loaded without any data transfer. That catches a counter that resets on Stop, or one that moves on at the acknowledge instead of at the byte load.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } rd_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

endpackage

// File: rtl/i2cr_line_cond.sv
module i2cr_line_cond
    import i2cr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_last;
        logic                   sda_last;
    } line_t;

    line_t line_d, line_q;
    logic  scl_now, sda_now;

    assign scl_now = line_q.scl_pipe[SYNC_STAGES-1];
    assign sda_now = line_q.sda_pipe[SYNC_STAGES-1];

    always_comb begin
        line_d          = line_q;
        line_d.scl_pipe = {line_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        line_d.sda_pipe = {line_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        line_d.scl_last = scl_now;
        line_d.sda_last = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '{scl_pipe: '1, sda_pipe: '1, scl_last: 1'b1, sda_last: 1'b1};
        end else begin
            line_q <= line_d;
        end
    end

    // Start and Stop are data edges while the clock stays high in both samples.
    always_comb begin
        ev_o.scl   = scl_now;
        ev_o.sda   = sda_now;
        ev_o.rise  = scl_now & ~line_q.scl_last;
        ev_o.fall  = ~scl_now & line_q.scl_last;
        ev_o.start = scl_now & line_q.scl_last & ~sda_now & line_q.sda_last;
        ev_o.stop  = scl_now & line_q.scl_last & sda_now & ~line_q.sda_last;
    end

endmodule

// File: rtl/i2cr_array.sv
module i2cr_array
    import i2cr_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R1: a side-port write is visible at the written location one cycle later.
    p_preload_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/i2cr_rd_ctrl.sv
module i2cr_rd_ctrl
    import i2cr_pkg::*;
#(
    parameter int          AW     = 9,
    parameter logic [3:0]  DEV_ID = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev_i,
    input  logic [3-(AW-8)-1:0] chip_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [AW-1:0]     rd_addr_o,
    output logic              sda_oe_o
);

    localparam int HI_W = AW - 8;

    typedef struct packed {
        rd_state_e         st;
        logic [3:0]        bit_cnt;
        logic [BYTE_W-1:0] sh;
        logic [AW-1:0]     cnt;
        logic [6:0]        sel_held;
        logic              dummy_pend;
        logic              oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic id_ok;
    logic load_byte;

    always_comb begin
        ctl_d     = ctl_q;
        load_byte = 1'b0;
        id_ok     = (ctl_q.sh[7:4] == DEV_ID) && (ctl_q.sh[3:HI_W+1] == chip_sel_i);

        if (ev_i.start) begin
            ctl_d.st      = ST_SEL;
            ctl_d.bit_cnt = '0;
            ctl_d.oe      = 1'b0;
        end else if (ev_i.stop) begin
            ctl_d.st         = ST_IDLE;
            ctl_d.oe         = 1'b0;
            ctl_d.dummy_pend = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_SEL: begin
                    if (ev_i.rise) begin
                        ctl_d.sh      = {ctl_q.sh[6:0], ev_i.sda};
                        ctl_d.bit_cnt = ctl_q.bit_cnt + 4'd1;
                    end else if (ev_i.fall && ctl_q.bit_cnt == 4'd8) begin
                        if (!id_ok) begin
                            ctl_d.st = ST_WAIT;
                        end else if (!ctl_q.sh[0]) begin
                            ctl_d.st         = ST_SEL_ACK;
                            ctl_d.oe         = 1'b1;
                            ctl_d.sel_held   = ctl_q.sh[7:1];
                            ctl_d.dummy_pend = 1'b1;
                        end else if (ctl_q.dummy_pend && ctl_q.sh[7:1] != ctl_q.sel_held) begin
                            ctl_d.st         = ST_WAIT;
                            ctl_d.dummy_pend = 1'b0;
                        end else begin
                            ctl_d.st         = ST_SEL_ACK;
                            ctl_d.oe         = 1'b1;
                            ctl_d.dummy_pend = 1'b0;
                        end
                    end
                end
                ST_SEL_ACK: begin
                    if (ev_i.fall) begin
                        ctl_d.oe = 1'b0;
                        if (ctl_q.sh[0]) begin
                            load_byte = 1'b1;
                        end else begin
                            ctl_d.st      = ST_ADR;
                            ctl_d.bit_cnt = '0;
                        end
                    end
                end
                ST_ADR: begin
                    if (ev_i.rise) begin
                        ctl_d.sh      = {ctl_q.sh[6:0], ev_i.sda};
                        ctl_d.bit_cnt = ctl_q.bit_cnt + 4'd1;
                    end else if (ev_i.fall && ctl_q.bit_cnt == 4'd8) begin
                        ctl_d.cnt = {ctl_q.sel_held[HI_W-1:0], ctl_q.sh};
                        ctl_d.oe  = 1'b1;
                        ctl_d.st  = ST_ADR_ACK;
                    end
                end
                ST_ADR_ACK: begin
                    if (ev_i.fall) begin
                        ctl_d.oe = 1'b0;
                        ctl_d.st = ST_WAIT;
                    end
                end
                ST_TX: begin
                    if (ev_i.fall) begin
                        if (ctl_q.bit_cnt == 4'd7) begin
                            ctl_d.oe = 1'b0;
                            ctl_d.st = ST_MACK;
                        end else begin
                            ctl_d.sh      = {ctl_q.sh[6:0], 1'b0};
                            ctl_d.oe      = ~ctl_q.sh[6];
                            ctl_d.bit_cnt = ctl_q.bit_cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_i.rise && ev_i.sda) begin
                        ctl_d.st = ST_WAIT;
                    end else if (ev_i.fall) begin
                        load_byte = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end

        if (load_byte) begin
            ctl_d.sh      = rd_data_i;
            ctl_d.cnt     = ctl_q.cnt + 1'b1;
            ctl_d.oe      = ~rd_data_i[7];
            ctl_d.bit_cnt = '0;
            ctl_d.st      = ST_TX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, bit_cnt: '0, sh: '0, cnt: '0,
                       sel_held: '0, dummy_pend: 1'b0, oe: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_addr_o = ctl_q.cnt;
    assign sda_oe_o  = ctl_q.oe;

    // R9: the pull-down never changes while the sampled clock is high.
    p_oe_quiet_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.scl && $past(ev_i.scl)) |-> $stable(ctl_q.oe));

    // R3: entering a byte transmission moves the counter on by exactly one, modulo the array size.
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TX && $past(ctl_q.st) != ST_TX) |-> ctl_q.cnt == $past(ctl_q.cnt) + 1'b1);

    // R7: a not-acknowledge from the master leaves the line released.
    p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_MACK && ev_i.rise && ev_i.sda && !ev_i.start && !ev_i.stop)
        |=> (ctl_q.st == ST_WAIT && !ctl_q.oe));

    // R8: a select byte with the wrong device bits is never acknowledged.
    p_bad_id_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SEL && ev_i.fall && ctl_q.bit_cnt == 4'd8 && ctl_q.sh[7:4] != DEV_ID)
        |=> !ctl_q.oe);

    // R5: a read select differing from the pending write select is refused.
    p_mismatch_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SEL && ev_i.fall && ctl_q.bit_cnt == 4'd8 && ctl_q.sh[0]
         && ctl_q.dummy_pend && ctl_q.sh[7:1] != ctl_q.sel_held)
        |=> (ctl_q.st == ST_WAIT && !ctl_q.oe));

    // R7: while waiting for the next Start the line is never pulled.
    p_wait_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.st == ST_WAIT |-> !ctl_q.oe);

endmodule

// File: rtl/i2cr_eeprom_rd.sv
module i2cr_eeprom_rd
    import i2cr_pkg::*;
#(
    parameter int         AW          = 9,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wc_i,
    input  logic [3-(AW-8)-1:0] chip_sel_i,
    input  logic              pl_we_i,
    input  logic [AW-1:0]     pl_addr_i,
    input  logic [BYTE_W-1:0] pl_data_i
);

    bus_ev_t           bus_ev;
    logic [AW-1:0]     rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              unused_wc;

    // Reads are independent of the write-control pin.
    assign unused_wc = wc_i;

    i2cr_line_cond #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_line (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (bus_ev)
    );

    i2cr_array #(
        .AW (AW)
    ) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (pl_we_i),
        .waddr_i (pl_addr_i),
        .wdata_i (pl_data_i),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    i2cr_rd_ctrl #(
        .AW     (AW),
        .DEV_ID (DEV_ID)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (bus_ev),
        .chip_sel_i (chip_sel_i),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .sda_oe_o   (sda_oe_o)
    );

endmodule

// File: tb/test_i2cr_eeprom_rd.sv
module test_i2cr_eeprom_rd;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wc = 1'b0;
    logic [1:0] pins = 2'b10;
    logic       pl_we = 1'b0;
    logic [8:0] pl_addr = '0;
    logic [7:0] pl_data = '0;
    logic       sda_oe;
    logic       sda_bus;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] ref_mem [512];
    int         ref_cnt = 0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2cr_eeprom_rd i_i2cr_eeprom_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .wc_i       (wc),
        .chip_sel_i (pins),
        .pl_we_i    (pl_we),
        .pl_addr_i  (pl_addr),
        .pl_data_i  (pl_data)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    function automatic logic [7:0] sel(input logic a8, input logic rw, input logic [1:0] p);
        return {4'b1010, p, a8, rw};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison: the pull-down must hold still while the bus clock stays high (R9).
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev) begin
            check(sda_oe == oe_prev, "R9 drive changed with SCL high", int'(sda_oe), int'(oe_prev));
        end
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic bit_c(input logic b, output logic seen);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        seen = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_c(b[i], s);
        bit_c(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_c(1'b1, s);
            b[i] = s;
        end
        bit_c(~mack, s);
    endtask

    // Reads n bytes after an accepted read select, acknowledging all but the last.
    task automatic read_seq(input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, b);
            check(b == ref_mem[ref_cnt], req, b, ref_mem[ref_cnt]);
            ref_cnt = (ref_cnt + 1) % 512;
        end
    endtask

    task automatic cur_read(input int n, input string req);
        logic ack;
        start_c();
        put_byte(sel(1'b0, 1'b1, pins), ack);
        check(ack, {req, " select ack"}, ack, 1);
        read_seq(n, req);
        stop_c();
    endtask

    task automatic rand_read(input int addr, input int n, input string req);
        logic ack;
        logic a8;
        a8 = addr[8];
        start_c();
        put_byte(sel(a8, 1'b0, pins), ack);
        check(ack, {req, " write select ack"}, ack, 1);
        put_byte(addr[7:0], ack);
        check(ack, {req, " address ack"}, ack, 1);
        ref_cnt = addr;
        start_c();
        put_byte(sel(a8, 1'b1, pins), ack);
        check(ack, {req, " read select ack"}, ack, 1);
        read_seq(n, req);
        stop_c();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        // R10: released line after reset.
        check(sda_oe == 1'b0, "R10 reset drive", sda_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sda_oe == 1'b0, "R10 idle drive", sda_oe, 0);

        // R1: fill the array through the side port.
        for (int i = 0; i < 512; i++) begin
            pl_we = 1'b1; pl_addr = 9'(i); pl_data = pat(i); ref_mem[i] = pat(i);
            @(negedge clk);
        end
        pl_we = 1'b0;

        // R10 / R6 / R2: first current read starts at 0, with write control high.
        wc = 1'b1;
        cur_read(2, "R10 R6 R2 current read from reset");

        // R4 / R7 / R2: random read in the upper half, write control low.
        wc = 1'b0;
        rand_read(9'h1F0, 3, "R4 R7 random sequential");

        // R6: counter persists across Stop.
        wc = 1'b1;
        cur_read(1, "R6 current after stop");

        // R3: sequential read across the top of the array.
        rand_read(9'h1FE, 4, "R3 wrap");

        // R5: read select differs in bit 1 from the write select.
        start_c();
        put_byte(sel(1'b1, 1'b0, pins), ack);
        check(ack, "R5 write select ack", ack, 1);
        put_byte(8'h10, ack);
        check(ack, "R5 address ack", ack, 1);
        start_c();
        put_byte(sel(1'b0, 1'b1, pins), ack);
        check(!ack, "R5 mismatched select refused", ack, 0);
        get_byte(1'b1, b);
        check(b == 8'hFF, "R5 no data after refusal", b, 8'hFF);
        stop_c();
        ref_cnt = 9'h110;
        cur_read(1, "R6 counter loaded by address write");

        // R8: wrong device bits, then wrong strap bits.
        start_c();
        put_byte(8'hB1, ack);
        check(!ack, "R8 wrong device id", ack, 0);
        get_byte(1'b1, b);
        check(b == 8'hFF, "R8 silent after wrong id", b, 8'hFF);
        stop_c();
        start_c();
        put_byte(sel(1'b0, 1'b1, 2'b01), ack);
        check(!ack, "R8 wrong strap bits", ack, 0);
        stop_c();

        // R7: after a not-acknowledge the block stays off the line.
        start_c();
        put_byte(sel(1'b0, 1'b1, pins), ack);
        check(ack, "R7 select ack", ack, 1);
        read_seq(2, "R7 sequential");
        get_byte(1'b0, b);
        check(b == 8'hFF, "R7 silent after master nack", b, 8'hFF);
        stop_c();
        cur_read(1, "R7 R3 counter after nack");

        // R1: side-port rewrite shows up on the bus; zeros and ones exercise R9.
        pl_we = 1'b1; pl_addr = 9'd5; pl_data = 8'hC3; ref_mem[5] = 8'hC3;
        @(negedge clk);
        pl_we = 1'b1; pl_addr = 9'd6; pl_data = 8'h00; ref_mem[6] = 8'h00;
        @(negedge clk);
        pl_we = 1'b1; pl_addr = 9'd7; pl_data = 8'hFF; ref_mem[7] = 8'hFF;
        @(negedge clk);
        pl_we = 1'b0;
        wc = 1'b0;
        rand_read(5, 3, "R1 R9 rewritten bytes");

        repeat (10) @(negedge clk);
        check(sda_oe == 1'b0, "R9 released at end", sda_oe, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule